// File: doc/BRIEF.md
# Pin Edge Interrupt and Wake Unit

This unit watches a port of up to 32 input pins and records edges on them. Each pin has two enable bits, one for rising edges and one for falling edges. Setting both makes the pin respond to either edge. An enabled edge is caught by a pair of capture flops that the pin itself clocks. Because of this, an event is recorded even while the system clock is stopped, and a wake request is raised at once from those flops.

The captured flags pass through a synchronizer into the system clock domain. There they are readable as two status words, one for rising and one for falling. The OR of all synchronized status bits drives a single interrupt line. Software clears a pin's two flags by writing a one to that pin's bit in a clear register. Register access uses a plain write strobe with combinational read data.

Top module: `gpio_edge_wake`

## Requirements
- R1: After reset both enable words and both status words read zero, and `irq_o` and `wake_o` are low.
- R2: When bit k of the rising-enable word (address 0) is set, a rising edge on pin k sets bit k of the rising-status word (address 2) within SYNC_STAGES+1 clock cycles.
- R3: When bit k of the falling-enable word (address 1) is set, a falling edge on pin k sets bit k of the falling-status word (address 3) within SYNC_STAGES+1 clock cycles.
- R4: An edge on a pin whose enable for that edge direction is zero changes no status bit and raises neither `irq_o` nor `wake_o`.
- R5: A pin with both enables set records its rising edges and its falling edges in the two separate status words.
- R6: `wake_o` rises as soon as an enabled edge occurs, even while the system clock is stopped.
- R7: `irq_o` is high exactly when some bit of the rising-status word or the falling-status word is set.
- R8: Writing to the clear register (address 4) clears both flags of every pin whose data bit is 1. Pins whose data bit is 0 keep their flags.
- R9: Clearing an enable bit does not remove a flag that has already been captured.
- R10: Enable words read back what was written. The clear register and the unused addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, may be stopped |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Monitored port pins |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | N_PINS | Write data |
| rd_data_o | output | N_PINS | Combinational read data for addr_i |
| irq_o | output | 1 | Combined interrupt, clock domain |
| wake_o | output | 1 | Wake request straight from the capture flops |

## Verification
The bench drives the following edge patterns:
- an isolated rising edge on a rising-only pin;
- a falling edge on a falling-only pin;
- both directions on a pin with both enables set;
- edges on pins that have no enables.

Together these show whether each direction reaches its own status word and whether the enables really gate capture. Two pins are captured and only one is cleared, which shows that the clear acts on single bits. Disabling a pin after capture shows that the flag is held. Edges applied while the clock is frozen separate the clock-free wake path from the synchronized interrupt path: `wake_o` must rise while `irq_o` stays low until the clock runs again.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      REG_RISE_EN = 3'd0,
      REG_FALL_EN = 3'd1,
      REG_RISE_ST = 3'd2,
      REG_FALL_ST = 3'd3,
      REG_CLEAR   = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/gpio_edge_cell.sv
// One pin: clock-free capture of enabled edges, async cleared.
module gpio_edge_cell (
   input  logic pin_i,
   input  logic clr_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   output logic rise_q_o,
   output logic fall_q_o
);
   always_ff @(posedge pin_i or posedge clr_i) begin
      if (clr_i)          rise_q_o <= 1'b0;
      else if (rise_en_i) rise_q_o <= 1'b1;
   end

   always_ff @(negedge pin_i or posedge clr_i) begin
      if (clr_i)          fall_q_o <= 1'b0;
      else if (fall_en_i) fall_q_o <= 1'b1;
   end
endmodule

// File: rtl/gpio_edge_sync.sv
// Multi-stage synchronizer for a vector of independent flags.
module gpio_edge_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_edge_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q[s] <= '0;
         else if (s == 0) stg_q[s] <= d_i;
         else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_regs.sv
// Enable registers, clear pulse generation and read mux.
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int N_PINS = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [N_PINS-1:0] wr_data_i,
   input  logic [N_PINS-1:0] rise_st_i,
   input  logic [N_PINS-1:0] fall_st_i,
   output logic [N_PINS-1:0] rise_en_o,
   output logic [N_PINS-1:0] fall_en_o,
   output logic [N_PINS-1:0] clr_o,
   output logic [N_PINS-1:0] rd_data_o
);
   reg_addr_e addr_e;
   assign addr_e = reg_addr_e'(addr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_en_o <= '0;
         fall_en_o <= '0;
         clr_o     <= '0;
      end else begin
         clr_o <= (wr_en_i && addr_e == REG_CLEAR) ? wr_data_i : '0;
         if (wr_en_i && addr_e == REG_RISE_EN) rise_en_o <= wr_data_i;
         if (wr_en_i && addr_e == REG_FALL_EN) fall_en_o <= wr_data_i;
      end
   end

   always_comb begin
      case (addr_e)
         REG_RISE_EN: rd_data_o = rise_en_o;
         REG_FALL_EN: rd_data_o = fall_en_o;
         REG_RISE_ST: rd_data_o = rise_st_i;
         REG_FALL_ST: rd_data_o = fall_st_i;
         default:     rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/gpio_edge_wake.sv
module gpio_edge_wake
   import gpio_edge_pkg::*;
#(
   parameter int N_PINS      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_PINS-1:0] pin_i,
   input  logic [2:0]        addr_i,
   input  logic              wr_en_i,
   input  logic [N_PINS-1:0] wr_data_i,
   output logic [N_PINS-1:0] rd_data_o,
   output logic              irq_o,
   output logic              wake_o
);
   if (N_PINS < 1 || N_PINS > 32) begin : g_bad_width
      $error("gpio_edge_wake: N_PINS must lie in 1..32");
   end

   logic [N_PINS-1:0] rise_en, fall_en, clr_q;
   logic [N_PINS-1:0] cap_rise, cap_fall;
   logic [N_PINS-1:0] rise_st, fall_st;
   logic [N_PINS-1:0] cap_clr;

   gpio_edge_regs #(.N_PINS(N_PINS)) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_i    (addr_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rise_st_i (rise_st),
      .fall_st_i (fall_st),
      .rise_en_o (rise_en),
      .fall_en_o (fall_en),
      .clr_o     (clr_q),
      .rd_data_o (rd_data_o)
   );

   for (genvar k = 0; k < N_PINS; k++) begin : g_pin
      assign cap_clr[k] = clr_q[k] | ~rst_ni;
      gpio_edge_cell cell_i (
         .pin_i     (pin_i[k]),
         .clr_i     (cap_clr[k]),
         .rise_en_i (rise_en[k]),
         .fall_en_i (fall_en[k]),
         .rise_q_o  (cap_rise[k]),
         .fall_q_o  (cap_fall[k])
      );
   end

   gpio_edge_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_rise_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (cap_rise), .q_o (rise_st)
   );
   gpio_edge_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_fall_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (cap_fall), .q_o (fall_st)
   );

   assign irq_o  = |{rise_st, fall_st};
   assign wake_o = |{cap_rise, cap_fall};
endmodule

// File: rtl/gpio_edge_wake_chk.sv
module gpio_edge_wake_chk #(
   parameter int N_PINS = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [2:0]        addr_i,
   input logic [N_PINS-1:0] rd_data_o,
   input logic              irq_o,
   input logic [N_PINS-1:0] clr_q,
   input logic [N_PINS-1:0] cap_rise,
   input logic [N_PINS-1:0] cap_fall
);
   AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !irq_o); // R1

   AST_STATUS_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((addr_i == 3'd2 || addr_i == 3'd3) && rd_data_o != '0) |-> irq_o); // R7

   AST_CLEAR_EMPTIES_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_q & (cap_rise | cap_fall)) == '0); // R8

   AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i >= 3'd4) |-> (rd_data_o == '0)); // R10
endmodule

bind gpio_edge_wake gpio_edge_wake_chk #(.N_PINS(N_PINS)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .addr_i    (addr_i),
   .rd_data_o (rd_data_o),
   .irq_o     (irq_o),
   .clr_q     (clr_q),
   .cap_rise  (cap_rise),
   .cap_fall  (cap_fall)
);

// File: tb/gpio_edge_wake_tb_top.sv
module gpio_edge_wake_tb_top;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         clk_run = 1'b1;
   logic         rst_n = 1'b0;
   logic [N-1:0] pins = '0;
   logic [2:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic [N-1:0] wr_data = '0;
   logic [N-1:0] rd_data;
   logic         irq, wake;
   int           n_run = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always begin
      #4;
      if (clk_run) clk = ~clk;
   end

   gpio_edge_wake #(.N_PINS(N), .SYNC_STAGES(2)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .pin_i (pins), .addr_i (addr),
      .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_data),
      .irq_o (irq), .wake_o (wake)
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_pin(input int k, input logic v);
      @(negedge clk);
      pins[k] = v;
      wait_cyc(4);
   endtask

   task automatic clear_all();
      wr(3'd4, '1);
      wait_cyc(4);
      wr(3'd0, '0);
      wr(3'd1, '0);
   endtask

   task automatic t_reset();
      logic [N-1:0] d;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 register zero after reset", d, '0);
      end
      check("R1 irq low after reset", N'(irq), '0);
      check("R1 wake low after reset", N'(wake), '0);
   endtask

   task automatic t_regmap();
      logic [N-1:0] d;
      wr(3'd0, 32'hA5A5_0F0F);
      wr(3'd1, 32'h3C3C_F0F0);
      rd(3'd0, d); check("R10 rise enable readback", d, 32'hA5A5_0F0F);
      rd(3'd1, d); check("R10 fall enable readback", d, 32'h3C3C_F0F0);
      rd(3'd4, d); check("R10 clear reads zero", d, '0);
      rd(3'd6, d); check("R10 unused address reads zero", d, '0);
      wr(3'd0, '0);
      wr(3'd1, '0);
   endtask

   task automatic t_rise();
      logic [N-1:0] d;
      wr(3'd0, 32'h8);
      set_pin(3, 1'b1);
      rd(3'd2, d); check("R2 rise status pin 3", d, 32'h8);
      rd(3'd3, d); check("R2 no fall status", d, '0);
      check("R7 irq with status set", N'(irq), 1);
      set_pin(3, 1'b0);
      rd(3'd3, d); check("R4 fall edge without fall enable", d, '0);
      clear_all();
      check("R7 irq low after clear", N'(irq), 0);
   endtask

   task automatic t_fall();
      logic [N-1:0] d;
      pins[9] = 1'b1;
      wait_cyc(2);
      wr(3'd1, 32'h200);
      set_pin(9, 1'b0);
      rd(3'd3, d); check("R3 fall status pin 9", d, 32'h200);
      rd(3'd2, d); check("R3 no rise status", d, '0);
      clear_all();
   endtask

   task automatic t_disabled();
      logic [N-1:0] d;
      wr(3'd0, 32'h1);
      wr(3'd1, 32'h1);
      set_pin(5, 1'b1);
      set_pin(5, 1'b0);
      rd(3'd2, d); check("R4 rise status unchanged", d, '0);
      rd(3'd3, d); check("R4 fall status unchanged", d, '0);
      check("R4 wake stays low", N'(wake), 0);
      check("R4 irq stays low", N'(irq), 0);
      clear_all();
   endtask

   task automatic t_both();
      logic [N-1:0] d;
      wr(3'd0, 32'h80);
      wr(3'd1, 32'h80);
      set_pin(7, 1'b1);
      rd(3'd2, d); check("R5 rise captured", d, 32'h80);
      rd(3'd3, d); check("R5 fall not yet", d, '0);
      wr(3'd4, 32'h80);
      wait_cyc(4);
      set_pin(7, 1'b0);
      rd(3'd3, d); check("R5 fall captured", d, 32'h80);
      rd(3'd2, d); check("R5 rise stays cleared", d, '0);
      clear_all();
   endtask

   task automatic t_clear_sel();
      logic [N-1:0] d;
      wr(3'd0, 32'h48);
      set_pin(3, 1'b1);
      set_pin(6, 1'b1);
      rd(3'd2, d); check("R8 two pins captured", d, 32'h48);
      wr(3'd4, 32'h8);
      wait_cyc(4);
      rd(3'd2, d); check("R8 only pin 3 cleared", d, 32'h40);
      pins[3] = 1'b0; pins[6] = 1'b0;
      wait_cyc(2);
      clear_all();
   endtask

   task automatic t_hold();
      logic [N-1:0] d;
      wr(3'd0, 32'h2);
      set_pin(1, 1'b1);
      wr(3'd0, '0);
      wait_cyc(4);
      rd(3'd2, d); check("R9 flag kept after disable", d, 32'h2);
      pins[1] = 1'b0;
      wait_cyc(2);
      clear_all();
   endtask

   task automatic t_stopped();
      logic [N-1:0] d;
      wr(3'd0, 32'h10000);
      @(negedge clk);
      clk_run = 1'b0;
      #20 pins[16] = 1'b1;
      #2 check("R6 wake with clock stopped", N'(wake), 1);
      check("R6 irq waits for clock", N'(irq), 0);
      #20 clk_run = 1'b1;
      wait_cyc(4);
      rd(3'd2, d); check("R6 status after restart", d, 32'h10000);
      pins[16] = 1'b0;
      wait_cyc(2);
      clear_all();
      check("R8 wake low after clear", N'(wake), 0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      wait_cyc(3);
      t_reset();
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_regmap();
      t_rise();
      t_fall();
      t_disabled();
      t_both();
      t_clear_sel();
      t_hold();
      t_stopped();
      summary();
   end
endmodule